// File: doc/BRIEF.md
# Dual-Descriptor Submission Validator

This block sits between a four-dword submission-port write and a per-engine context queue. One write carries two 64-bit context descriptors. The block decodes both and checks them as a pair. It either rejects the whole write with an error code, or it forwards the valid descriptors to the queue one at a time through a valid/ready handshake.

Each forwarded descriptor comes out as separate fields: validity, privilege bit, addressing mode, page-table depth, context ID and address tag. The first descriptor forwarded from a write is marked as the one that carries the schedule-in request, and later descriptors from the same write are not. While descriptors from one write are still waiting to drain, the block does not take another write. Fetching ring contexts and building page tables are left to later stages, apart from the check that the addressing mode is supported.

Top module: `sub_validator`

## Requirements
- R1: The write is packed as {dw3,dw2,dw1,dw0}, with dw0 in bits [31:0]. Descriptor 0 is dw2 (low word) with dw3 (high word), and descriptor 1 is dw0 (low) with dw1 (high). In a low word, bit 0 is valid, bit 1 is privilege, bits [4:3] are the addressing mode and bits [31:12] are the address tag. The high word is the context ID.
- R2: When both descriptors are valid and accepted, descriptor 0 is offered first and descriptor 1 second.
- R3: Only the first descriptor forwarded from a write has q_sched_in high.
- R4: When descriptor 0 alone is valid, exactly one descriptor is forwarded, and it has q_sched_in high.
- R5: If any valid descriptor has privilege 0, the write is rejected with code 1 and nothing is forwarded. An invalid descriptor's privilege bit is ignored.
- R6: A write in which neither descriptor is valid is rejected with code 2.
- R7: A write in which descriptor 0 is invalid and descriptor 1 is valid is rejected with code 3.
- R8: Mode 1 gives q_levels = 3 and mode 3 gives q_levels = 4. A valid descriptor with mode 0 or 2 rejects the write with code 4, and nothing is forwarded.
- R9: When several rejection causes apply, the code reported follows the priority 1 > 2 > 3 > 4.
- R10: sub_ready is low from acceptance until the last descriptor's handshake. Under back-pressure, q_valid and the offered fields hold steady.
- R11: After reset, sub_ready = 1, q_valid = 0, err_strobe = 0 and err_code = 0.
- R12: Each rejected write raises err_strobe for one cycle, in the cycle after acceptance, with err_code nonzero. err_code is 0 whenever err_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submission write present |
| sub_data | input | 128 | Four packed dwords of the write |
| sub_ready | output | 1 | Block can take a write |
| q_valid | output | 1 | Descriptor offered to queue |
| q_ready | input | 1 | Queue accepts descriptor |
| q_sched_in | output | 1 | Offered descriptor carries schedule-in |
| q_desc_vld | output | 1 | Valid bit of offered descriptor |
| q_priv | output | 1 | Privilege bit of offered descriptor |
| q_mode | output | 2 | Addressing mode |
| q_levels | output | 3 | Page-table depth (3 or 4) |
| q_ctx_id | output | 32 | Context ID |
| q_addr_tag | output | 20 | Address tag |
| err_strobe | output | 1 | One-cycle rejection pulse |
| err_code | output | 3 | Rejection cause |

## Verification
The writes cover several patterns. With both descriptors valid, the test shows that dword order and forwarding order are right and that the schedule-in flag appears only once. With descriptor 0 alone valid, it shows that a single item is forwarded and that the invalid slot's privilege bit plays no part. Writes with a single cause each for privilege, empty, order and mode errors tell the error codes apart. Writes that combine causes confirm the priority. A held-off queue shows that the offered descriptor stays stable and that new writes are blocked until the queue drains.

// File: rtl/sub_validator_pkg.sv
package sub_validator_pkg;
    parameter int DW_W     = 32;
    localparam int TAG_LSB = 12;
    localparam int TAG_W   = DW_W - TAG_LSB;
    localparam int CTX_W   = DW_W;
    localparam int VLD_BIT = 0;
    localparam int PRV_BIT = 1;
    localparam int MODE_LSB = 3;
    localparam int NDESC   = 2;

    typedef struct packed {
        logic             vld;
        logic             priv;
        logic [1:0]       mode;
        logic [2:0]       levels;
        logic             mode_ok;
        logic [CTX_W-1:0] ctx;
        logic [TAG_W-1:0] tag;
    } desc_t;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_PRIV  = 3'd1,
        ERR_EMPTY = 3'd2,
        ERR_ORDER = 3'd3,
        ERR_MODE  = 3'd4
    } err_e;
endpackage

// File: rtl/desc_decode.sv
module desc_decode
    import sub_validator_pkg::*;
(
    input  logic [DW_W-1:0] lo_dw,
    input  logic [DW_W-1:0] hi_dw,
    output desc_t           desc
);
    logic [1:0] mode_w;

    always_comb begin
        mode_w       = lo_dw[MODE_LSB +: 2];
        desc.vld     = lo_dw[VLD_BIT];
        desc.priv    = lo_dw[PRV_BIT];
        desc.mode    = mode_w;
        desc.tag     = lo_dw[TAG_LSB +: TAG_W];
        desc.ctx     = hi_dw;
        desc.levels  = 3'd0;
        desc.mode_ok = 1'b0;
        case (mode_w)
            2'd1: begin desc.levels = 3'd3; desc.mode_ok = 1'b1; end
            2'd3: begin desc.levels = 3'd4; desc.mode_ok = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/sub_check.sv
module sub_check
    import sub_validator_pkg::*;
(
    input  desc_t d0,
    input  desc_t d1,
    output err_e  err,
    output logic  two
);
    logic priv_bad, mode_bad;

    always_comb begin
        priv_bad = (d0.vld && !d0.priv) || (d1.vld && !d1.priv);
        mode_bad = (d0.vld && !d0.mode_ok) || (d1.vld && !d1.mode_ok);
        if (priv_bad)                 err = ERR_PRIV;
        else if (!d0.vld && !d1.vld)  err = ERR_EMPTY;
        else if (!d0.vld)             err = ERR_ORDER;
        else if (mode_bad)            err = ERR_MODE;
        else                          err = ERR_NONE;
        two = d0.vld && d1.vld;
    end
endmodule

// File: rtl/sub_validator.sv
module sub_validator
    import sub_validator_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sub_valid,
    input  logic [4*DW_W-1:0]    sub_data,
    output logic                 sub_ready,
    output logic                 q_valid,
    input  logic                 q_ready,
    output logic                 q_sched_in,
    output logic                 q_desc_vld,
    output logic                 q_priv,
    output logic [1:0]           q_mode,
    output logic [2:0]           q_levels,
    output logic [CTX_W-1:0]     q_ctx_id,
    output logic [TAG_W-1:0]     q_addr_tag,
    output logic                 err_strobe,
    output logic [2:0]           err_code
);
    typedef struct packed {
        logic              busy;
        logic              head;
        logic              last;
        logic              first;
        desc_t [NDESC-1:0] slot;
        logic              err_stb;
        err_e              code;
    } st_t;

    st_t   st_d, st_q;
    desc_t dec [NDESC];
    err_e  chk_err;
    logic  chk_two;
    desc_t cur;

    // descriptor i uses dwords (2-2i, 3-2i): reversed pair order
    for (genvar gi = 0; gi < NDESC; gi++) begin : g_dec
        localparam int LO = 2*(NDESC-1-gi);
        desc_decode u_dec (
            .lo_dw (sub_data[LO*DW_W     +: DW_W]),
            .hi_dw (sub_data[(LO+1)*DW_W +: DW_W]),
            .desc  (dec[gi])
        );
    end

    sub_check u_chk (
        .d0  (dec[0]),
        .d1  (dec[1]),
        .err (chk_err),
        .two (chk_two)
    );

    always_comb begin
        st_d         = st_q;
        st_d.err_stb = 1'b0;
        st_d.code    = ERR_NONE;
        if (!st_q.busy && sub_valid) begin
            if (chk_err != ERR_NONE) begin
                st_d.err_stb = 1'b1;
                st_d.code    = chk_err;
            end else begin
                st_d.busy    = 1'b1;
                st_d.head    = 1'b0;
                st_d.first   = 1'b1;
                st_d.last    = !chk_two;
                st_d.slot[0] = dec[0];
                st_d.slot[1] = dec[1];
            end
        end else if (st_q.busy && q_ready) begin
            if (st_q.last) begin
                st_d.busy  = 1'b0;
                st_d.first = 1'b0;
            end else begin
                st_d.head  = 1'b1;
                st_d.last  = 1'b1;
                st_d.first = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cur        = st_q.slot[st_q.head];
        sub_ready  = !st_q.busy;
        q_valid    = st_q.busy;
        q_sched_in = st_q.busy && st_q.first;
        q_desc_vld = cur.vld;
        q_priv     = cur.priv;
        q_mode     = cur.mode;
        q_levels   = cur.levels;
        q_ctx_id   = cur.ctx;
        q_addr_tag = cur.tag;
        err_strobe = st_q.err_stb;
        err_code   = st_q.code;
    end

    // R10
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid && !q_ready |=> q_valid && $stable(q_ctx_id) && $stable(q_sched_in));
    // R10
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sub_ready && q_valid));
    // R3
    one_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid && q_ready |=> !q_sched_in);
    // R5
    rej_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> !q_valid);
    // R8
    levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> (q_levels == 3'd3 || q_levels == 3'd4));
    // R12
    code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> err_code != 3'd0);
endmodule

// File: tb/tb_sub_validator.sv
module tb_sub_validator;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sub_valid = 1'b0;
    logic [127:0] sub_data = '0;
    logic         sub_ready, q_valid, q_sched_in, q_desc_vld, q_priv;
    logic         q_ready = 1'b1;
    logic [1:0]   q_mode;
    logic [2:0]   q_levels;
    logic [31:0]  q_ctx_id;
    logic [19:0]  q_addr_tag;
    logic         err_strobe;
    logic [2:0]   err_code;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    sub_validator dut (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_data(sub_data),
        .sub_ready(sub_ready), .q_valid(q_valid), .q_ready(q_ready),
        .q_sched_in(q_sched_in), .q_desc_vld(q_desc_vld), .q_priv(q_priv),
        .q_mode(q_mode), .q_levels(q_levels), .q_ctx_id(q_ctx_id),
        .q_addr_tag(q_addr_tag), .err_strobe(err_strobe), .err_code(err_code)
    );

    function automatic logic [31:0] lo(bit v, bit p, logic [1:0] m, logic [19:0] t);
        return {t, 7'd0, m, 1'b0, p, v};
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // d0 = {hi0, lo0} goes into dw3/dw2, d1 into dw1/dw0
    task automatic submit(logic [31:0] lo0, logic [31:0] hi0,
                          logic [31:0] lo1, logic [31:0] hi1);
        sub_data  = {hi0, lo0, hi1, lo1};
        sub_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sub_valid = 1'b0;
    endtask

    task automatic expect_desc(string req, logic [31:0] ctx, logic [19:0] tag,
                               bit sched, logic [2:0] lv);
        chk(q_valid == 1'b1, req, q_valid, 1);
        chk(q_ctx_id == ctx, req, q_ctx_id, ctx);
        chk(q_addr_tag == tag, req, q_addr_tag, tag);
        chk(q_sched_in == sched, {req, " sched"}, q_sched_in, sched);
        chk(q_levels == lv, {req, " levels"}, q_levels, lv);
        chk(sub_ready == 1'b0, {req, " R10 ready"}, sub_ready, 0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_idle(string req);
        chk(q_valid == 1'b0, req, q_valid, 0);
        chk(sub_ready == 1'b1, req, sub_ready, 1);
    endtask

    task automatic expect_err(string req, logic [2:0] code);
        chk(err_strobe == 1'b1, req, err_strobe, 1);
        chk(err_code == code, req, err_code, code);
        chk(q_valid == 1'b0, {req, " nofwd"}, q_valid, 0);
        @(negedge clk);
        chk(err_strobe == 1'b0, {req, " R12 pulse"}, err_strobe, 0);
        chk(err_code == 3'd0, {req, " R12 code"}, err_code, 0);
        chk(q_valid == 1'b0, {req, " nofwd later"}, q_valid, 0);
    endtask

    task automatic t_both;
        submit(lo(1,1,2'd1,20'hAAAAA), 32'h1111_0000, lo(1,1,2'd3,20'h55555), 32'h2222_0000);
        expect_desc("R1 R2 first", 32'h1111_0000, 20'hAAAAA, 1, 3'd3);
        expect_desc("R2 R3 second", 32'h2222_0000, 20'h55555, 0, 3'd4);
        expect_idle("R2 drained");
    endtask

    task automatic t_single;
        submit(lo(1,1,2'd3,20'h00F0F), 32'hCAFE_0001, lo(0,0,2'd0,20'h12345), 32'hDEAD_BEEF);
        expect_desc("R4 R5 single", 32'hCAFE_0001, 20'h00F0F, 1, 3'd4);
        expect_idle("R4 one only");
    endtask

    task automatic t_backpressure;
        q_ready = 1'b0;
        submit(lo(1,1,2'd1,20'h00001), 32'h0000_00A0, lo(1,1,2'd1,20'h00002), 32'h0000_00B0);
        for (int i = 0; i < 4; i++) begin
            chk(q_valid && q_ctx_id == 32'hA0 && q_sched_in, "R10 hold", q_ctx_id, 32'hA0);
            chk(sub_ready == 1'b0, "R10 blocked", sub_ready, 0);
            @(negedge clk);
        end
        // a write offered now must be ignored
        sub_data = {32'h0000_0BAD, lo(1,1,2'd1,20'h0), 64'd0};
        sub_valid = 1'b1;
        @(negedge clk);
        sub_valid = 1'b0;
        chk(q_ctx_id == 32'hA0, "R10 ignored write", q_ctx_id, 32'hA0);
        q_ready = 1'b1;
        expect_desc("R10 first", 32'h0000_00A0, 20'h00001, 1, 3'd3);
        expect_desc("R10 second", 32'h0000_00B0, 20'h00002, 0, 3'd3);
        expect_idle("R10 drained");
    endtask

    task automatic t_errors;
        submit(lo(1,0,2'd1,20'h1), 32'h1, lo(1,1,2'd1,20'h2), 32'h2);
        expect_err("R5 priv d0", 3'd1);
        submit(lo(1,1,2'd1,20'h1), 32'h1, lo(1,0,2'd1,20'h2), 32'h2);
        expect_err("R5 priv d1", 3'd1);
        submit(lo(0,1,2'd1,20'h1), 32'h1, lo(0,1,2'd3,20'h2), 32'h2);
        expect_err("R6 empty", 3'd2);
        submit(lo(0,1,2'd1,20'h1), 32'h1, lo(1,1,2'd1,20'h2), 32'h2);
        expect_err("R7 order", 3'd3);
        submit(lo(1,1,2'd0,20'h1), 32'h1, lo(0,1,2'd1,20'h2), 32'h2);
        expect_err("R8 mode0", 3'd4);
        submit(lo(1,1,2'd1,20'h1), 32'h1, lo(1,1,2'd2,20'h2), 32'h2);
        expect_err("R8 mode2 d1", 3'd4);
        submit(lo(0,1,2'd1,20'h1), 32'h1, lo(1,0,2'd0,20'h2), 32'h2);
        expect_err("R9 priv over order", 3'd1);
        submit(lo(0,1,2'd1,20'h1), 32'h1, lo(1,1,2'd2,20'h2), 32'h2);
        expect_err("R9 order over mode", 3'd3);
        submit(lo(1,0,2'd2,20'h1), 32'h1, lo(0,0,2'd0,20'h2), 32'h2);
        expect_err("R9 priv over mode", 3'd1);
        expect_idle("R12 after errors");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(sub_ready == 1'b1, "R11 ready", sub_ready, 1);
        chk(q_valid == 1'b0, "R11 qvalid", q_valid, 0);
        chk(err_strobe == 1'b0, "R11 strobe", err_strobe, 0);
        chk(err_code == 3'd0, "R11 code", err_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_both();
        t_single();
        t_errors();
        t_backpressure();
        t_both();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule